// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

This block controls a bank of general-purpose pins through a word-wide register interface. Software drives each pin's output latch through separate set and clear registers, chooses direction per pin, and reads the synchronized pin levels. The total pin count is a parameter. Pins are packed 32 to a data word, so the last word may hold fewer than 32 pins.

Each pin has independent rising-edge and falling-edge enables. An enabled transition on the synchronized input sets a sticky status bit, and software clears that bit by writing a one to it. Pin 0 and pin 1 each drive a dedicated interrupt line. Every higher pin feeds one shared interrupt line. A 2-bit function field per pin hands control of the pin's output and output enable to an alternate peripheral whenever the field is nonzero.

The register address is `{kind[2:0], index[IDX_W-1:0]}`. Reads are combinational in the cycle where `bus_sel` is high and `bus_we` is low. Writes take effect at the clock edge that samples `bus_sel` and `bus_we` both high.

Top module: `gpio_bank`

## Requirements
- R1: A write to kind 2 (set) sets the output latch of every pin whose data bit is 1 and leaves bits written 0 unchanged. A read of kind 2 returns the latch.
- R2: A write to kind 3 (clear) clears the latch of every pin whose data bit is 1 and leaves bits written 0 unchanged. Kind 3 reads as 0.
- R3: Kind 1 (direction) is read/write. With a pin's function field at 0, `pin_oe_o` equals its direction bit (1 = output) and `pin_o` equals its latch bit.
- R4: Kind 0 (level) returns each pin's input after a two-flop synchronizer, for outputs and inputs alike. A change on `pin_i` is visible two clock edges later. Writes to kind 0 have no effect.
- R5: Kind 4 holds the rising-edge enables and kind 5 holds the falling-edge enables. A synchronized 0→1 change with its rising enable set, or a 1→0 change with its falling enable set, sets the pin's status bit. With both enables set, either direction sets it. With neither set, no change sets it.
- R6: Kind 6 (status) bits are sticky. Writing 1 clears a bit. Writing 0 leaves it unchanged.
- R7: If an enabled edge and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R8: Kind 7 holds the function fields, 16 pins per word. Pin n uses bits [2*(n%16)+1 : 2*(n%16)] of word n/16. `alt_sel_o[2n+1:2n]` carries the field.
- R9: With a nonzero function field, `pin_o` and `pin_oe_o` of that pin follow `alt_out_i` and `alt_oe_i`.
- R10: `irq_pin0_o` and `irq_pin1_o` equal status bits 0 and 1. `irq_shared_o` is the OR of the status bits of pins 2 and above.
- R11: Bits of unpopulated pins read 0 and ignore writes. An index past the last word of a kind reads 0.
- R12: After reset all registers are 0: every pin is an input with latch 0, no edge enabled, status clear, all function fields 0, and all interrupts low.
- R13: Kind codes are 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status, 7 function. The low IDX_W address bits select the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+3 | {kind, word index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not reading) |
| pin_i | input | NUM_PINS | Raw pin inputs |
| pin_o | output | NUM_PINS | Pin output values |
| pin_oe_o | output | NUM_PINS | Pin output enables |
| alt_out_i | input | NUM_PINS | Alternate peripheral output values |
| alt_oe_i | input | NUM_PINS | Alternate peripheral output enables |
| alt_sel_o | output | 2*NUM_PINS | Per-pin function fields |
| irq_pin0_o | output | 1 | Interrupt of pin 0 |
| irq_pin1_o | output | 1 | Interrupt of pin 1 |
| irq_shared_o | output | 1 | Combined interrupt of pins 2 and above |

## Verification
Assertions check four behaviours on every cycle:
- A status bit rises only after an enabled edge on that pin, and falls only after a clear write to it.
- An edge that coincides with a clear wins.
- Set and clear writes reach the latch one edge later.
- An interrupt line rises only after an edge on its own pins.

The unpopulated bits of the last word are also checked on every read.

Other behaviours only the bench scenarios can show:
- The two-flop latency from `pin_i` to the level register.
- The bit placement of the packed function fields.
- The hand-over of `pin_o` and `pin_oe_o` to the alternate inputs.
- The full reset contents.
- The register contents that result from random mixes of writes and pin activity.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W         = 32;
    localparam int FN_FIELD_W     = 2;
    localparam int KIND_W         = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_LEVEL = 3'd0,
        KIND_DIR   = 3'd1,
        KIND_SET   = 3'd2,
        KIND_CLR   = 3'd3,
        KIND_RISE  = 3'd4,
        KIND_FALL  = 3'd5,
        KIND_STAT  = 3'd6,
        KIND_FUNC  = 3'd7
    } gpio_kind_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage2;

endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] edge_o,
    output logic [W-1:0] status_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] status;
    } edge_t;

    edge_t        edge_d, edge_q;
    logic [W-1:0] edge_w;

    // An edge is a difference between this and the previous synchronized sample
    assign edge_w = (lvl_i & ~edge_q.prev & rise_en_i)
                  | (~lvl_i & edge_q.prev & fall_en_i);

    always_comb begin
        edge_d        = edge_q;
        edge_d.prev   = lvl_i;
        // New edge has priority over a concurrent clear
        edge_d.status = (edge_q.status & ~clr_i) | edge_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign edge_o   = edge_w;
    assign status_o = edge_q.status;

    p_set_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((edge_q.status & ~$past(edge_q.status) & ~$past(edge_w)) == '0));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(edge_q.status) & ~edge_q.status & ~$past(clr_i)) == '0));

    p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_w & clr_i) != '0) |=>
            ((edge_q.status & $past(edge_w & clr_i)) == $past(edge_w & clr_i)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 53,
    parameter int IDX_W    = 3,
    localparam int ADDR_W  = IDX_W + KIND_W,
    localparam int FN_BITS = FN_FIELD_W * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] level_i,
    input  logic [NUM_PINS-1:0] status_i,
    output logic [NUM_PINS-1:0] dir_o,
    output logic [NUM_PINS-1:0] latch_o,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o,
    output logic [FN_BITS-1:0]  fn_o,
    output logic [NUM_PINS-1:0] clr_o
);

    localparam int NUM_WORDS    = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int NUM_FN_WORDS = (FN_BITS + WORD_W - 1) / WORD_W;
    localparam int BITS_W       = NUM_WORDS * WORD_W;
    localparam int FBITS_W      = NUM_FN_WORDS * WORD_W;
    localparam int LAST_BITS    = NUM_PINS - WORD_W * (NUM_WORDS - 1);
    localparam int SH_W         = IDX_W + 5;

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] rise;
        logic [NUM_PINS-1:0] fall;
        logic [FN_BITS-1:0]  fn;
    } regs_t;

    regs_t regs_d, regs_q;

    gpio_kind_e          kind;
    logic [IDX_W-1:0]    idx;
    logic [SH_W-1:0]     shamt;
    logic                wr, rd;
    logic [BITS_W-1:0]   wide_data, wide_mask, rd_wide;
    logic [FBITS_W-1:0]  fwide_data, fwide_mask, rd_fwide;
    logic [NUM_PINS-1:0] wbits, wsel;
    logic [FN_BITS-1:0]  fbits, fsel;

    assign kind  = gpio_kind_e'(bus_addr[ADDR_W-1:IDX_W]);
    assign idx   = bus_addr[IDX_W-1:0];
    assign shamt = {idx, 5'd0};
    assign wr    = bus_sel & bus_we;
    assign rd    = bus_sel & ~bus_we;

    // Place the 32-bit data word at its slot; out-of-range slots shift out to zero
    assign wide_data  = BITS_W'(bus_wdata) << shamt;
    assign wide_mask  = BITS_W'({WORD_W{1'b1}}) << shamt;
    assign fwide_data = FBITS_W'(bus_wdata) << shamt;
    assign fwide_mask = FBITS_W'({WORD_W{1'b1}}) << shamt;
    assign wbits      = wide_data[NUM_PINS-1:0];
    assign wsel       = wide_mask[NUM_PINS-1:0];
    assign fbits      = fwide_data[FN_BITS-1:0];
    assign fsel       = fwide_mask[FN_BITS-1:0];

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            unique case (kind)
                KIND_DIR:  regs_d.dir   = (regs_q.dir  & ~wsel) | (wbits & wsel);
                KIND_SET:  regs_d.latch = regs_q.latch | wbits;
                KIND_CLR:  regs_d.latch = regs_q.latch & ~wbits;
                KIND_RISE: regs_d.rise  = (regs_q.rise & ~wsel) | (wbits & wsel);
                KIND_FALL: regs_d.fall  = (regs_q.fall & ~wsel) | (wbits & wsel);
                KIND_FUNC: regs_d.fn    = (regs_q.fn   & ~fsel) | (fbits & fsel);
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign clr_o = (wr && kind == KIND_STAT) ? wbits : '0;

    always_comb begin
        rd_wide  = '0;
        rd_fwide = FBITS_W'(regs_q.fn);
        unique case (kind)
            KIND_LEVEL: rd_wide = BITS_W'(level_i);
            KIND_DIR:   rd_wide = BITS_W'(regs_q.dir);
            KIND_SET:   rd_wide = BITS_W'(regs_q.latch);
            KIND_CLR:   rd_wide = '0;
            KIND_RISE:  rd_wide = BITS_W'(regs_q.rise);
            KIND_FALL:  rd_wide = BITS_W'(regs_q.fall);
            KIND_STAT:  rd_wide = BITS_W'(status_i);
            default:    rd_wide = '0;
        endcase
    end

    always_comb begin
        if (!rd)                    bus_rdata = '0;
        else if (kind == KIND_FUNC) bus_rdata = WORD_W'(rd_fwide >> shamt);
        else                        bus_rdata = WORD_W'(rd_wide >> shamt);
    end

    assign dir_o   = regs_q.dir;
    assign latch_o = regs_q.latch;
    assign rise_o  = regs_q.rise;
    assign fall_o  = regs_q.fall;
    assign fn_o    = regs_q.fn;

    p_set_reaches_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == KIND_SET) |=> ((regs_q.latch & $past(wbits)) == $past(wbits)));

    p_clr_reaches_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == KIND_CLR) |=> ((regs_q.latch & $past(wbits)) == '0));

    p_unpop_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && kind != KIND_FUNC && idx == IDX_W'(NUM_WORDS - 1))
            |-> ((bus_rdata >> LAST_BITS) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 53,
    parameter int IDX_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [IDX_W+KIND_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    input  logic [NUM_PINS-1:0]       pin_i,
    output logic [NUM_PINS-1:0]       pin_o,
    output logic [NUM_PINS-1:0]       pin_oe_o,
    input  logic [NUM_PINS-1:0]       alt_out_i,
    input  logic [NUM_PINS-1:0]       alt_oe_i,
    output logic [FN_FIELD_W*NUM_PINS-1:0] alt_sel_o,
    output logic                      irq_pin0_o,
    output logic                      irq_pin1_o,
    output logic                      irq_shared_o
);

    localparam int FN_BITS = FN_FIELD_W * NUM_PINS;

    logic [NUM_PINS-1:0] level_w, status_w, edge_w, clr_w;
    logic [NUM_PINS-1:0] dir_w, latch_w, rise_w, fall_w;
    logic [FN_BITS-1:0]  fn_w;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (level_w)
    );

    gpio_edge #(.W(NUM_PINS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (level_w),
        .rise_en_i (rise_w),
        .fall_en_i (fall_w),
        .clr_i     (clr_w),
        .edge_o    (edge_w),
        .status_o  (status_w)
    );

    gpio_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level_i   (level_w),
        .status_i  (status_w),
        .dir_o     (dir_w),
        .latch_o   (latch_w),
        .rise_o    (rise_w),
        .fall_o    (fall_w),
        .fn_o      (fn_w),
        .clr_o     (clr_w)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic alt_active;
        assign alt_active  = |fn_w[FN_FIELD_W*p +: FN_FIELD_W];
        assign pin_o[p]    = alt_active ? alt_out_i[p] : latch_w[p];
        assign pin_oe_o[p] = alt_active ? alt_oe_i[p]  : dir_w[p];
    end

    assign alt_sel_o    = fn_w;
    assign irq_pin0_o   = status_w[0];
    assign irq_pin1_o   = status_w[1];
    assign irq_shared_o = |status_w[NUM_PINS-1:2];

    p_irq0_follows_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pin0_o) |-> $past(edge_w[0]));

    p_irq_shared_follows_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_shared_o) |-> $past(|edge_w[NUM_PINS-1:2]));

endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;

    localparam int NP    = 53;
    localparam int IDX_W = 3;
    localparam int NW    = (NP + 31) / 32;
    localparam int NFW   = (2 * NP + 31) / 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_we = 1'b0;
    logic [IDX_W+2:0]  bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_i = '0, pin_o, pin_oe_o;
    logic [NP-1:0]     alt_out_i = '0, alt_oe_i = '0;
    logic [2*NP-1:0]   alt_sel_o;
    logic              irq_pin0_o, irq_pin1_o, irq_shared_o;

    always #2 clk = ~clk;

    gpio_bank #(.NUM_PINS(NP), .IDX_W(IDX_W)) i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
        .alt_out_i(alt_out_i), .alt_oe_i(alt_oe_i), .alt_sel_o(alt_sel_o),
        .irq_pin0_o(irq_pin0_o), .irq_pin1_o(irq_pin1_o), .irq_shared_o(irq_shared_o)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [NP-1:0]   m_dir = '0, m_latch = '0, m_rise = '0, m_fall = '0, m_stat = '0;
    logic [2*NP-1:0] m_fn = '0;

    function automatic logic [31:0] word_of(logic [NP-1:0] v, int idx);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) if (idx * 32 + b < NP) r[b] = v[idx * 32 + b];
        return r;
    endfunction

    function automatic logic [31:0] fword_of(int idx);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) if (idx * 32 + b < 2 * NP) r[b] = m_fn[idx * 32 + b];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(int kind, int idx);
        case (kind)
            0: return word_of(pin_i, idx);
            1: return word_of(m_dir, idx);
            2: return word_of(m_latch, idx);
            4: return word_of(m_rise, idx);
            5: return word_of(m_fall, idx);
            6: return word_of(m_stat, idx);
            7: return fword_of(idx);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(int kind, int idx, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = {kind[2:0], idx[2:0]}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        for (int b = 0; b < 32; b++) begin
            int p = idx * 32 + b;
            if (p < NP) begin
                case (kind)
                    1: m_dir[p]  = d[b];
                    2: if (d[b]) m_latch[p] = 1'b1;
                    3: if (d[b]) m_latch[p] = 1'b0;
                    4: m_rise[p] = d[b];
                    5: m_fall[p] = d[b];
                    6: if (d[b]) m_stat[p] = 1'b0;
                    default: ;
                endcase
            end
            if (kind == 7 && p < 2 * NP) m_fn[p] = d[b];
        end
    endtask

    task automatic bus_rd(int kind, int idx, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {kind[2:0], idx[2:0]};
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(string req, int kind, int idx);
        logic [31:0] d;
        bus_rd(kind, idx, d);
        check(req, $sformatf("read kind %0d word %0d", kind, idx), 128'(d), 128'(exp_rd(kind, idx)));
    endtask

    task automatic toggle(logic [NP-1:0] t);
        logic [NP-1:0] old;
        @(negedge clk);
        old   = pin_i;
        pin_i = pin_i ^ t;
        m_stat = m_stat | (pin_i & ~old & m_rise) | (~pin_i & old & m_fall);
        repeat (4) @(negedge clk);
    endtask

    task automatic pins_chk(string req);
        logic [NP-1:0] eo, eoe;
        @(negedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            if (m_fn[2*p +: 2] != 2'b00) begin eo[p] = alt_out_i[p]; eoe[p] = alt_oe_i[p]; end
            else begin eo[p] = m_latch[p]; eoe[p] = m_dir[p]; end
        end
        check(req, "pin_o", 128'(pin_o), 128'(eo));
        check(req, "pin_oe_o", 128'(pin_oe_o), 128'(eoe));
        check(req, "alt_sel_o", 128'(alt_sel_o), 128'(m_fn));
        check("R10", "irq_pin0_o", 128'(irq_pin0_o), 128'(m_stat[0]));
        check("R10", "irq_pin1_o", 128'(irq_pin1_o), 128'(m_stat[1]));
        check("R10", "irq_shared_o", 128'(irq_shared_o), 128'(|m_stat[NP-1:2]));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset contents
        for (int k = 0; k < 8; k++) for (int i = 0; i < NW; i++) rd_chk("R12", k, i);
        for (int i = 0; i < NFW; i++) rd_chk("R12", 7, i);
        pins_chk("R12");

        // R1 / R2 / R3: latch via set and clear, direction
        bus_wr(2, 0, 32'h0000_00A5);
        bus_rd(2, 0, d); check("R1", "latch after set", 128'(d), 128'(32'hA5));
        bus_wr(2, 0, 32'h0);
        bus_rd(2, 0, d); check("R1", "latch after set of 0", 128'(d), 128'(32'hA5));
        bus_wr(3, 0, 32'h0000_0005);
        bus_rd(2, 0, d); check("R2", "latch after clear", 128'(d), 128'(32'hA0));
        bus_rd(3, 0, d); check("R2", "clear reads 0", 128'(d), 128'(0));
        bus_wr(1, 0, 32'h0000_00F0);
        pins_chk("R3");

        // R4: level of an output pin and of an input pin, writes ignored
        toggle(NP'(64'h0000_0001_0000_0088));
        bus_rd(0, 0, d); check("R4", "level word 0", 128'(d), 128'(32'h88));
        bus_wr(0, 0, 32'hFFFF_FFFF);
        bus_rd(0, 1, d); check("R4", "level word 1", 128'(d), 128'(32'h1));
        bus_rd(0, 0, d); check("R4", "level after write", 128'(d), 128'(32'h88));
        @(negedge clk); pin_i[9] = 1'b1;
        @(negedge clk); #1 bus_sel = 1'b1; bus_addr = 6'd0;
        #0 check("R4", "level one edge after change", 128'(bus_rdata[9]), 128'(0));
        bus_sel = 1'b0;
        @(negedge clk); #1 bus_sel = 1'b1;
        #0 check("R4", "level two edges after change", 128'(bus_rdata[9]), 128'(1));
        bus_sel = 1'b0;

        // R5: enable combinations on pins 10 (rise), 11 (fall), 12 (both), 13 (none)
        bus_wr(4, 0, 32'h0000_1400);
        bus_wr(5, 0, 32'h0000_1800);
        toggle(NP'(64'h3C00));
        bus_rd(6, 0, d); check("R5", "status after rise", 128'(d & 32'h3C00), 128'(32'h1400));
        toggle(NP'(64'h3C00));
        bus_rd(6, 0, d); check("R5", "status after fall", 128'(d & 32'h3C00), 128'(32'h1C00));

        // R6: write 0 keeps, write 1 clears
        bus_wr(6, 0, 32'h0);
        bus_rd(6, 0, d); check("R6", "status after write 0", 128'(d & 32'h3C00), 128'(32'h1C00));
        bus_wr(6, 0, 32'h0000_0400);
        bus_rd(6, 0, d); check("R6", "status after w1c", 128'(d & 32'h3C00), 128'(32'h1800));

        // R7: clear lands in the same cycle as a new edge on pin 12
        bus_wr(6, 0, 32'hFFFF_FFFF);
        @(negedge clk); pin_i[12] = ~pin_i[12];
        @(negedge clk);
        bus_wr(6, 0, 32'h0000_1000);
        m_stat[12] = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(6, 0, d); check("R7", "edge wins over clear", 128'(d[12]), 128'(1));

        // R8 / R9: function field for pin 17 in word 1, bits [3:2]
        bus_wr(7, 1, 32'h0000_0008);
        check("R8", "alt_sel pin17", 128'(alt_sel_o[35:34]), 128'(2'b10));
        bus_rd(7, 1, d); check("R8", "function word 1", 128'(d), 128'(32'h8));
        @(negedge clk); alt_out_i[17] = 1'b1; alt_oe_i[17] = 1'b1;
        #1 check("R9", "pin17 from alt", 128'({pin_o[17], pin_oe_o[17]}), 128'(2'b11));
        pins_chk("R9");

        // R10: dedicated and shared interrupts
        bus_wr(6, 0, 32'hFFFF_FFFF); bus_wr(6, 1, 32'hFFFF_FFFF);
        bus_wr(4, 0, 32'h0000_0003); bus_wr(4, 1, 32'h0000_0100);
        toggle(NP'(64'h0000_0100_0000_0001) & ~pin_i);
        pins_chk("R10");
        toggle(NP'(64'h2) & ~pin_i);
        pins_chk("R10");

        // R11: unpopulated bits and out-of-range words
        bus_wr(1, 1, 32'hFFFF_FFFF);
        bus_rd(1, 1, d); check("R11", "dir word 1 width", 128'(d), 128'(32'h001F_FFFF));
        bus_wr(1, 3, 32'hFFFF_FFFF);
        bus_rd(1, 3, d); check("R11", "dir out-of-range word", 128'(d), 128'(0));
        bus_wr(7, 3, 32'hFFFF_FFFF);
        bus_rd(7, 3, d); check("R11", "function word 3 width", 128'(d), 128'(32'h3FF));
        bus_rd(7, 5, d); check("R11", "function out-of-range word", 128'(d), 128'(0));

        // R13: random mix checked against the model
        for (int it = 0; it < 500; it++) begin
            int op = int'($urandom % 4);
            if (op == 0) bus_wr(int'($urandom % 8), int'($urandom % 5), $urandom);
            else if (op == 1) toggle(NP'({$urandom, $urandom}) & NP'({$urandom, $urandom}));
            else if (op == 2) begin
                @(negedge clk);
                alt_out_i = NP'({$urandom, $urandom});
                alt_oe_i  = NP'({$urandom, $urandom});
            end
            rd_chk("R13", int'($urandom % 8), int'($urandom % 5));
            if (it % 4 == 0) pins_chk("R13");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule